// File: doc/BRIEF.md
# Three-Wire Serial Settings Port

This block is a write-only control port for an audio output stage. A host clocks bits in on a data line with a shift clock, most significant bit first. It then raises a request line, and the last eight bits received become one command. If the top bit of the command is 0, the other seven bits are an attenuation code. If the top bit is 1, the upper nibble picks one small setting register: de-emphasis, format with mute, test, step rate, full reset or datapath reset. The stored settings are held on the outputs. A full reset and a datapath reset each appear as a one-cycle pulse.

All three serial lines come from outside and are not tied to the block's clock. Each passes through a synchroniser before its edges are detected. A mode input chooses where the format comes from. In serial mode the stored format code is used. In parallel mode the same three pins carry the format code directly, and the port accepts no writes. An active-low asynchronous power-on reset and an active-low external reset both clear the settings. The external reset is synchronised first.

Top module: `serctl_top`

## Requirements
- R1: A bit is shifted in on each synchronised rising edge of `sck_i`, most significant bit first. On a rising edge of `req_i` only the last 8 bits shifted are used; any earlier bits have no effect.
- R2: A command with bit 7 = 0 loads bits 6..0 into `atten_o`. No other setting changes.
- R3: A command with bits 7..4 = 1000 loads bits 1..0 into `demp_o`: 00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz. Bits 3..2 are don't-care.
- R4: A command with bits 7..4 = 1001 loads bits 3..1 into the format code, with bit 3 as its MSB, and bit 0 into `mute_o`.
- R5: Bits 7..4 = 1100 loads bit 0 into `test_o`. Bits 7..4 = 1110 loads bits 2..0 into `step_o`.
- R6: Bits 7..4 = 1010 with bit 0 = 1 returns every setting to its default. It also raises `full_rst_o` and `dp_rst_o` together for exactly one cycle.
- R7: Bits 7..4 = 1111 with bit 0 = 1 raises `dp_rst_o` for exactly one cycle. No setting changes and `full_rst_o` stays low.
- R8: After reset, attenuation, de-emphasis, format, mute, test and step rate are all 0, and neither pulse output is high.
- R9: A low level on `ext_rst_ni` clears all settings to their defaults. It raises no pulse output.
- R10: With `mode_i` = 0, `fmt_o` equals {`sck_i`, `req_i`, `data_i`} after synchronisation, and request edges write nothing. With `mode_i` = 1, `fmt_o` shows the stored format code.
- R11: Prefixes 1011 and 1101 are ignored. So are prefix 1010 and prefix 1111 when bit 0 = 0. None of them changes a setting or raises a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_ni | input | 1 | External reset, active low, asynchronous to clk_i |
| mode_i | input | 1 | 1 = serial control, 0 = parallel format pins |
| sck_i | input | 1 | Shift clock; parallel mode: format bit 2 |
| req_i | input | 1 | Request strobe; parallel mode: format bit 1 |
| data_i | input | 1 | Serial data; parallel mode: format bit 0 |
| atten_o | output | 7 | Attenuation code |
| demp_o | output | 2 | De-emphasis select |
| fmt_o | output | 3 | Audio interface format code |
| mute_o | output | 1 | Mute setting |
| test_o | output | 1 | Test setting |
| step_o | output | 3 | Attenuator step-rate select |
| full_rst_o | output | 1 | One-cycle full reset pulse |
| dp_rst_o | output | 1 | One-cycle datapath reset pulse |

## Verification
The bench builds the block with SYNC_STAGES = 3, one stage above the default. Every line edge therefore reaches the logic only after a longer delay, and any timing that depends on the default depth would show up. It holds each line level for longer than the synchroniser delay plus edge detection. This reaches the corner cases: a burst longer than eight bits, back-to-back writes to every prefix, ignored prefixes, and a mode change while the port is active.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int WORD_W = 8;
  localparam int ATT_W  = WORD_W - 1;
  localparam int DEMP_W = 2;
  localparam int FMT_W  = 3;
  localparam int STEP_W = 3;
  localparam int PFX_W  = 4;

  typedef struct packed {
    logic [ATT_W-1:0]  atten;
    logic [DEMP_W-1:0] demp;
    logic [FMT_W-1:0]  fmt;
    logic              mute;
    logic              test;
    logic [STEP_W-1:0] step;
  } settings_t;

  localparam settings_t SETTINGS_DEF = '0;

  typedef enum logic [2:0] {
    OP_NONE, OP_ATT, OP_DEMP, OP_FMT, OP_FULL, OP_TEST, OP_STEP, OP_DP
  } op_e;

  localparam logic [PFX_W-1:0] PFX_DEMP = 4'b1000;
  localparam logic [PFX_W-1:0] PFX_FMT  = 4'b1001;
  localparam logic [PFX_W-1:0] PFX_FULL = 4'b1010;
  localparam logic [PFX_W-1:0] PFX_TEST = 4'b1100;
  localparam logic [PFX_W-1:0] PFX_STEP = 4'b1110;
  localparam logic [PFX_W-1:0] PFX_DP   = 4'b1111;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/serctl_shift.sv
module serctl_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sck_i,
  input  logic              data_i,
  output logic [WORD_W-1:0] word_o
);
  logic              sck_prev_q;
  logic [WORD_W-1:0] sh_q;
  logic              sck_rise;

  assign sck_rise = sck_i & ~sck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      sh_q       <= '0;
    end else begin
      sck_prev_q <= sck_i;
      if (clr_i)         sh_q <= '0;
      else if (sck_rise) sh_q <= {sh_q[WORD_W-2:0], data_i};
    end
  end

  assign word_o = sh_q;

  // without a shift edge the window holds
  p_hold_no_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_rise && !clr_i) |=> $stable(word_o));
  // newest bit enters at the LSB
  p_lsb_newest_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise && !clr_i) |=> (word_o[0] == $past(data_i)));
endmodule

// File: rtl/serctl_decode.sv
module serctl_decode
  import serctl_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output op_e               op_o
);
  logic [PFX_W-1:0] pfx;
  assign pfx = word_i[WORD_W-1 -: PFX_W];

  always_comb begin
    op_o = OP_NONE;
    if (!word_i[WORD_W-1]) begin
      op_o = OP_ATT;
    end else begin
      unique case (pfx)
        PFX_DEMP: op_o = OP_DEMP;
        PFX_FMT:  op_o = OP_FMT;
        PFX_FULL: op_o = word_i[0] ? OP_FULL : OP_NONE;
        PFX_TEST: op_o = OP_TEST;
        PFX_STEP: op_o = OP_STEP;
        PFX_DP:   op_o = word_i[0] ? OP_DP : OP_NONE;
        default:  op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs
  import serctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              serial_i,
  input  logic              req_i,
  input  logic [WORD_W-1:0] word_i,
  input  op_e               op_i,
  output settings_t         set_o,
  output logic              full_rst_o,
  output logic              dp_rst_o
);
  settings_t set_q;
  logic      req_prev_q;
  logic      full_q, dp_q;
  logic      wr;

  assign wr = req_i & ~req_prev_q & serial_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q      <= SETTINGS_DEF;
      req_prev_q <= 1'b0;
      full_q     <= 1'b0;
      dp_q       <= 1'b0;
    end else begin
      req_prev_q <= req_i;
      full_q     <= 1'b0;
      dp_q       <= 1'b0;
      if (clr_i) begin
        set_q <= SETTINGS_DEF;
      end else if (wr) begin
        case (op_i)
          OP_ATT:  set_q.atten <= word_i[ATT_W-1:0];
          OP_DEMP: set_q.demp  <= word_i[DEMP_W-1:0];
          OP_FMT: begin
            set_q.fmt  <= word_i[FMT_W:1];
            set_q.mute <= word_i[0];
          end
          OP_FULL: begin
            set_q  <= SETTINGS_DEF;
            full_q <= 1'b1;
            dp_q   <= 1'b1;
          end
          OP_TEST: set_q.test <= word_i[0];
          OP_STEP: set_q.step <= word_i[STEP_W-1:0];
          OP_DP:   dp_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign set_o      = set_q;
  assign full_rst_o = full_q;
  assign dp_rst_o   = dp_q;

  p_full_defaults_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rst_o |-> (set_o == SETTINGS_DEF));
  p_full_with_dp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rst_o |-> dp_rst_o);
  p_dp_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_rst_o |=> !dp_rst_o);
  p_clr_defaults_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (set_o == SETTINGS_DEF && !full_rst_o && !dp_rst_o));
  p_parallel_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!serial_i && !clr_i) |=> ($stable(set_o) && !dp_rst_o));
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr && !clr_i) |=> $stable(set_o));
endmodule

// File: rtl/serctl_top.sv
module serctl_top
  import serctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_ni,
  input  logic              mode_i,
  input  logic              sck_i,
  input  logic              req_i,
  input  logic              data_i,
  output logic [ATT_W-1:0]  atten_o,
  output logic [DEMP_W-1:0] demp_o,
  output logic [FMT_W-1:0]  fmt_o,
  output logic              mute_o,
  output logic              test_o,
  output logic [STEP_W-1:0] step_o,
  output logic              full_rst_o,
  output logic              dp_rst_o
);
  logic [2:0]        pins_s;
  logic              ext_rst_s;
  logic              clr;
  logic [WORD_W-1:0] word;
  op_e               op;
  settings_t         set;

  serctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({sck_i, req_i, data_i}), .q_o(pins_s)
  );

  serctl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_rst_ni), .q_o(ext_rst_s)
  );

  assign clr = ~ext_rst_s;

  serctl_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .sck_i(pins_s[2]), .data_i(pins_s[0]), .word_o(word)
  );

  serctl_decode u_dec (.word_i(word), .op_o(op));

  serctl_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .serial_i(mode_i),
    .req_i(pins_s[1]), .word_i(word), .op_i(op), .set_o(set),
    .full_rst_o(full_rst_o), .dp_rst_o(dp_rst_o)
  );

  assign atten_o = set.atten;
  assign demp_o  = set.demp;
  assign fmt_o   = mode_i ? set.fmt : pins_s;
  assign mute_o  = set.mute;
  assign test_o  = set.test;
  assign step_o  = set.step;

  p_serial_fmt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $stable(mode_i) && !full_rst_o && !clr && !$past(clr)) |->
      (fmt_o == u_regs.set_o.fmt));
endmodule

// File: tb/tb_serctl_top.sv
module tb_serctl_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 3;
  localparam int HOLD       = SYNC + 3;
  localparam int NVEC       = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ext_rst_n = 1'b1, mode = 1'b1;
  logic sck = 1'b0, req = 1'b0, data = 1'b0;
  logic [6:0] atten;
  logic [1:0] demp;
  logic [2:0] fmt, step;
  logic mute, test, full_rst, dp_rst;

  int n_chk = 0, n_fail = 0, n_full = 0, n_dp = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serctl_top #(.SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_rst_n), .mode_i(mode),
    .sck_i(sck), .req_i(req), .data_i(data),
    .atten_o(atten), .demp_o(demp), .fmt_o(fmt), .mute_o(mute),
    .test_o(test), .step_o(step), .full_rst_o(full_rst), .dp_rst_o(dp_rst)
  );

  always @(posedge clk) begin
    if (full_rst) n_full++;
    if (dp_rst)   n_dp++;
  end

  // {command, atten, demp, fmt, mute, test, step} cumulative expectation
  localparam logic [24:0] VEC [NVEC] = '{
    {8'h79, 7'h79, 2'd0, 3'd0, 1'b0, 1'b0, 3'd0},
    {8'h16, 7'h16, 2'd0, 3'd0, 1'b0, 1'b0, 3'd0},
    {8'h82, 7'h16, 2'd2, 3'd0, 1'b0, 1'b0, 3'd0},
    {8'h8B, 7'h16, 2'd3, 3'd0, 1'b0, 1'b0, 3'd0},
    {8'h9B, 7'h16, 2'd3, 3'd5, 1'b1, 1'b0, 3'd0},
    {8'h95, 7'h16, 2'd3, 3'd2, 1'b1, 1'b0, 3'd0},
    {8'hC1, 7'h16, 2'd3, 3'd2, 1'b1, 1'b1, 3'd0},
    {8'hE6, 7'h16, 2'd3, 3'd2, 1'b1, 1'b1, 3'd6},
    {8'hD5, 7'h16, 2'd3, 3'd2, 1'b1, 1'b1, 3'd6},
    {8'hB7, 7'h16, 2'd3, 3'd2, 1'b1, 1'b1, 3'd6},
    {8'hA0, 7'h16, 2'd3, 3'd2, 1'b1, 1'b1, 3'd6},
    {8'hF0, 7'h16, 2'd3, 3'd2, 1'b1, 1'b1, 3'd6},
    {8'h7F, 7'h7F, 2'd3, 3'd2, 1'b1, 1'b1, 3'd6}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) data = w[i];
      repeat (HOLD) @(negedge clk);
      sck = 1'b1;
      repeat (HOLD) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HOLD) @(negedge clk);
    req = 1'b1;
    repeat (HOLD) @(negedge clk);
    req = 1'b0;
    repeat (HOLD + 4) @(negedge clk);
  endtask

  function automatic logic [16:0] state();
    return {atten, demp, fmt, mute, test, step};
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R8: defaults
    check("R8 settings", {15'd0, state()}, 32'd0);
    check("R8 pulses", {30'd0, full_rst, dp_rst}, 32'd0);

    // R2 R3 R4 R5 R11: table walk
    for (int v = 0; v < NVEC; v++) begin
      send({8'h00, VEC[v][24:17]}, 8);
      check($sformatf("R2/R3/R4/R5/R11 vec%0d", v), {15'd0, state()}, {15'd0, VEC[v][16:0]});
    end
    check("R11 no pulses", n_full + n_dp, 0);

    // R1: 12-bit burst, only the last 8 bits count
    send(16'h0F05, 12);
    check("R1 last eight", atten, 7'h05);

    // R7: datapath reset only
    send(16'h00F1, 8);
    check("R7 dp pulse", n_dp, 1);
    check("R7 no full", n_full, 0);
    check("R7 settings kept", {15'd0, state()}, {15'd0, 7'h05, 2'd3, 3'd2, 1'b1, 1'b1, 3'd6});

    // R6: full reset
    send(16'h00A1, 8);
    check("R6 full pulse", n_full, 1);
    check("R6 dp pulse", n_dp, 2);
    check("R6 defaults", {15'd0, state()}, 32'd0);

    // R10: parallel mode
    send(16'h0030, 8);
    mode = 1'b0;
    @(negedge clk) sck = 1'b1; req = 1'b0; data = 1'b1;
    repeat (HOLD) @(negedge clk);
    check("R10 parallel fmt", fmt, 3'd5);
    send(16'h007F, 8);
    check("R10 no write", atten, 7'h30);
    mode = 1'b1;
    @(negedge clk);
    check("R10 serial fmt", fmt, 3'd0);

    // R9: external reset
    send(16'h0044, 8);
    send(16'h00E3, 8);
    check("R9 pre", {15'd0, state()}, {15'd0, 7'h44, 2'd0, 3'd0, 1'b0, 1'b0, 3'd3});
    ext_rst_n = 1'b0;
    repeat (10) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (HOLD) @(negedge clk);
    check("R9 cleared", {15'd0, state()}, 32'd0);
    check("R9 no pulse", n_full, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule